// File: doc/BRIEF.md
# Discrete-style cartridge bank mapper

This block is the CPU-side logic of a simple cartridge mapper built the way a few discrete logic chips would build it. An 8-bit latch holds a program-ROM bank number, a two-bit character-RAM bank number and a one-screen mirroring select. The lower 16 KiB CPU window ($8000-$BFFF) shows the selected program bank. The upper window ($C000-$FFFF) always shows the last bank, because CPU address bit 14 is ORed into every bank address bit.

Two static configuration pins choose the wiring. In locked wiring, any write in the ROM-select range loads the latch. The ROM drives the bus at the same time, so the value stored is the CPU data ANDed with the ROM byte. In flashable wiring, the range is split. A write to the upper half loads the latch with the CPU data unchanged. A write to the lower half pulses the flash write-enable instead. The ROM output-enable is only asserted on reads, so no bus conflict can occur. A second pin selects a 512 KiB part (five bank bits) or a 256 KiB part (four bank bits).

The block runs on a bus-rate clock. Each clock cycle carries one CPU bus cycle, and the latch loads at the clock edge that ends a qualifying write cycle.

Top module: `cart_bank_mapper`

## Requirements
- R1: The latch fields are bit 7 = one-screen mirroring select (`mirror_one`), bits 6:5 = character bank (`chr_bank`), and bits 4:0 = program bank, with bit 0 driving ROM A14.
- R2: Each output `rom_bank[i]` (ROM A14+i) equals `cpu_a14` OR program bank bit i. With `cpu_a14` = 1 and a 512 KiB part, `rom_bank` is all ones.
- R3: With `cfg_big` = 0 (256 KiB), `rom_bank[4]` is 0 at all times, whatever the latch or `cpu_a14` holds. With `cfg_big` = 1, all five bits follow R2.
- R4: With `cfg_flashable` = 0, a write cycle (`cpu_rw` = 0) with `romsel_n` = 0 loads the latch with `cpu_data & rom_data` at the clock edge ending that cycle. This holds for either value of `cpu_a14`.
- R5: With `cfg_flashable` = 0, `rom_oe_n` equals `romsel_n`, even during writes, and `rom_we_n` stays 1.
- R6: With `cfg_flashable` = 1, a write with `romsel_n` = 0 and `cpu_a14` = 1 loads `cpu_data` unchanged. `rom_data` has no effect on the value stored.
- R7: With `cfg_flashable` = 1, a write with `romsel_n` = 0 and `cpu_a14` = 0 drives `rom_we_n` = 0 during that cycle and leaves the latch unchanged.
- R8: With `cfg_flashable` = 1, `rom_oe_n` is 0 only on read cycles (`cpu_rw` = 1) with `romsel_n` = 0.
- R9: While `romsel_n` = 1 (CPU below $8000), `rom_oe_n` and `rom_we_n` are 1, and writes leave the latch unchanged.
- R10: Asserting `rst_n` low clears the latch at once, without waiting for a clock edge. After `rst_n` is released, no write is accepted until two clock edges have passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock, one CPU bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_flashable | input | 1 | Static wiring choice: 1 = flashable, 0 = locked |
| cfg_big | input | 1 | Static capacity choice: 1 = 512 KiB, 0 = 256 KiB |
| romsel_n | input | 1 | ROM-select strobe from the console, low for $8000-$FFFF |
| cpu_rw | input | 1 | CPU read/write line, 1 = read |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_data | input | 8 | CPU write data |
| rom_data | input | 8 | Byte the ROM presents at the current address |
| rom_bank | output | 5 | ROM address bits A14-A18 |
| rom_oe_n | output | 1 | ROM output-enable, active low |
| rom_we_n | output | 1 | ROM (flash) write-enable, active low |
| chr_bank | output | 2 | Character-RAM bank bits |
| mirror_one | output | 1 | One-screen mirroring select |

## Verification
The enables and `rom_bank` are combinational from the bus pins and the latch. The bench therefore checks them one time unit after it drives a bus cycle, and before the next clock edge. A latch load becomes visible after the single clock edge that ends the write cycle. Each write task drives its cycle after a falling edge, lets one rising edge pass, returns the bus to idle on the next falling edge, and only then reads the fields. The program bank is read through `rom_bank` with `cpu_a14` = 0. A reset is checked just after `rst_n` falls, with no clock edge in between.

// File: rtl/cart_bank_mapper_pkg.sv
package cart_bank_mapper_pkg;
  localparam int PRG_W  = 5;
  localparam int CHR_W  = 2;
  localparam int REG_W  = 1 + CHR_W + PRG_W;
  localparam int SYNC_N = 2;

  typedef struct packed {
    logic             mirror;
    logic [CHR_W-1:0] chr;
    logic [PRG_W-1:0] prg;
  } bank_reg_t;
endpackage

// File: rtl/cart_reset_sync.sv
module cart_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/cart_strobe_dec.sv
module cart_strobe_dec (
  input  logic cfg_flashable,
  input  logic romsel_n,
  input  logic cpu_rw,
  input  logic cpu_a14,
  output logic latch_en,
  output logic rom_oe_n,
  output logic rom_we_n
);
  logic sel_write;
  logic sel_read;

  always_comb begin
    sel_write = !romsel_n && !cpu_rw;
    sel_read  = !romsel_n && cpu_rw;
    if (cfg_flashable) begin
      latch_en = sel_write && cpu_a14;
      rom_we_n = !(sel_write && !cpu_a14);
      rom_oe_n = !sel_read;
    end else begin
      latch_en = sel_write;
      rom_we_n = 1'b1;
      rom_oe_n = romsel_n;
    end
  end
endmodule

// File: rtl/cart_bank_reg.sv
module cart_bank_reg
  import cart_bank_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             latch_en,
  input  logic             cfg_flashable,
  input  logic [REG_W-1:0] cpu_data,
  input  logic [REG_W-1:0] rom_data,
  output bank_reg_t        bank_q
);
  bank_reg_t        bank_d;
  logic [REG_W-1:0] load_val;

  always_comb begin
    load_val = cfg_flashable ? cpu_data : (cpu_data & rom_data);
    bank_d   = bank_q;
    if (latch_en) bank_d = bank_reg_t'(load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end
endmodule

// File: rtl/cart_prg_window.sv
module cart_prg_window
  import cart_bank_mapper_pkg::*;
(
  input  logic             cpu_a14,
  input  logic             cfg_big,
  input  logic [PRG_W-1:0] prg,
  output logic [PRG_W-1:0] rom_bank
);
  for (genvar i = 0; i < PRG_W; i++) begin : g_bit
    if (i == PRG_W - 1) begin : g_top
      assign rom_bank[i] = cfg_big & (cpu_a14 | prg[i]);
    end else begin : g_low
      assign rom_bank[i] = cpu_a14 | prg[i];
    end
  end
endmodule

// File: rtl/cart_bank_mapper.sv
module cart_bank_mapper
  import cart_bank_mapper_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_flashable,
  input  logic             cfg_big,
  input  logic             romsel_n,
  input  logic             cpu_rw,
  input  logic             cpu_a14,
  input  logic [REG_W-1:0] cpu_data,
  input  logic [REG_W-1:0] rom_data,
  output logic [PRG_W-1:0] rom_bank,
  output logic             rom_oe_n,
  output logic             rom_we_n,
  output logic [CHR_W-1:0] chr_bank,
  output logic             mirror_one
);
  logic             rst_core_n;
  logic             latch_en;
  bank_reg_t        reg_q;
  logic [REG_W-1:0] bank_q;

  cart_reset_sync #(.STAGES(SYNC_N)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  cart_strobe_dec u_dec (
    .cfg_flashable (cfg_flashable),
    .romsel_n      (romsel_n),
    .cpu_rw        (cpu_rw),
    .cpu_a14       (cpu_a14),
    .latch_en      (latch_en),
    .rom_oe_n      (rom_oe_n),
    .rom_we_n      (rom_we_n)
  );

  cart_bank_reg u_reg (
    .clk           (clk),
    .rst_n         (rst_core_n),
    .latch_en      (latch_en),
    .cfg_flashable (cfg_flashable),
    .cpu_data      (cpu_data),
    .rom_data      (rom_data),
    .bank_q        (reg_q)
  );

  cart_prg_window u_win (
    .cpu_a14  (cpu_a14),
    .cfg_big  (cfg_big),
    .prg      (reg_q.prg),
    .rom_bank (rom_bank)
  );

  assign bank_q     = reg_q;
  assign chr_bank   = reg_q.chr;
  assign mirror_one = reg_q.mirror;
endmodule

// File: rtl/cart_bank_mapper_chk.sv
module cart_bank_mapper_chk
  import cart_bank_mapper_pkg::*;
(
  input logic             clk,
  input logic             rst_core_n,
  input logic             cfg_flashable,
  input logic             cfg_big,
  input logic             romsel_n,
  input logic             cpu_rw,
  input logic             cpu_a14,
  input logic [REG_W-1:0] cpu_data,
  input logic [PRG_W-1:0] rom_bank,
  input logic             rom_oe_n,
  input logic             rom_we_n,
  input logic [REG_W-1:0] bank_q
);
  // R9
  no_sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    romsel_n |-> (rom_oe_n && rom_we_n));

  // R9
  no_sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    romsel_n |=> $stable(bank_q));

  // R7
  flash_prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_flashable && !romsel_n && !cpu_rw && !cpu_a14) |=> $stable(bank_q));

  // R7
  we_only_flash_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !rom_we_n |-> (cfg_flashable && !cpu_a14 && !cpu_rw && !romsel_n));

  // R8
  oe_read_only_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_flashable && !rom_oe_n) |-> (cpu_rw && !romsel_n));

  // R6
  flash_latch_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cfg_flashable && !romsel_n && !cpu_rw && cpu_a14) |=> (bank_q == $past(cpu_data)));

  // R2
  fixed_top_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (cpu_a14 && cfg_big) |-> (&rom_bank));

  // R3
  small_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    !cfg_big |-> !rom_bank[PRG_W-1]);
endmodule

bind cart_bank_mapper cart_bank_mapper_chk u_chk (
  .clk           (clk),
  .rst_core_n    (rst_core_n),
  .cfg_flashable (cfg_flashable),
  .cfg_big       (cfg_big),
  .romsel_n      (romsel_n),
  .cpu_rw        (cpu_rw),
  .cpu_a14       (cpu_a14),
  .cpu_data      (cpu_data),
  .rom_bank      (rom_bank),
  .rom_oe_n      (rom_oe_n),
  .rom_we_n      (rom_we_n),
  .bank_q        (bank_q)
);

// File: tb/cart_bank_mapper_test.sv
`timescale 1ns/1ps
module cart_bank_mapper_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_flashable, cfg_big, romsel_n, cpu_rw, cpu_a14;
  logic [7:0] cpu_data, rom_data;
  logic [4:0] rom_bank;
  logic       rom_oe_n, rom_we_n, mirror_one;
  logic [1:0] chr_bank;
  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cart_bank_mapper uut (
    .clk(clk), .rst_n(rst_n), .cfg_flashable(cfg_flashable), .cfg_big(cfg_big),
    .romsel_n(romsel_n), .cpu_rw(cpu_rw), .cpu_a14(cpu_a14),
    .cpu_data(cpu_data), .rom_data(rom_data), .rom_bank(rom_bank),
    .rom_oe_n(rom_oe_n), .rom_we_n(rom_we_n), .chr_bank(chr_bank),
    .mirror_one(mirror_one)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    romsel_n = 1'b1; cpu_rw = 1'b1; cpu_a14 = 1'b0;
  endtask

  // returns the latch as {mirror, chr, prg} read through the ports
  task automatic read_latch(output logic [7:0] v);
    cpu_a14 = 1'b0;
    #1 v = {mirror_one, chr_bank, rom_bank};
  endtask

  // one bus write cycle; bus back at idle afterwards
  task automatic bus_write(input logic a14, input logic [7:0] d, input logic [7:0] rd);
    @(negedge clk);
    romsel_n = 1'b0; cpu_rw = 1'b0; cpu_a14 = a14; cpu_data = d; rom_data = rd;
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    read_latch(v);
    chk("R10 latch zero after reset", v, 8'h00);
    chk("R9 oe idle", rom_oe_n, 1);
    chk("R9 we idle", rom_we_n, 1);
    cpu_a14 = 1'b1;
    #1 chk("R2 fixed window all ones", rom_bank, 5'h1f);
    cpu_a14 = 1'b0;
  endtask

  task automatic t_locked();
    logic [7:0] v;
    cfg_flashable = 1'b0; cfg_big = 1'b1;
    bus_write(1'b0, 8'hFF, 8'hA5);
    read_latch(v);
    chk("R4 locked load ANDed a14=0", v, 8'hA5);
    chk("R1 mirror bit7", mirror_one, 1);
    chk("R1 chr bits6:5", chr_bank, 2'b01);
    chk("R1 prg bits4:0", rom_bank, 5'h05);
    cpu_a14 = 1'b1;
    #1 chk("R2 OR of a14 into bank", rom_bank, 5'h1f);
    bus_write(1'b1, 8'h0F, 8'hFF);
    read_latch(v);
    chk("R4 locked load a14=1", v, 8'h0F);
    // R5: output enable during a write in locked wiring
    @(negedge clk);
    romsel_n = 1'b0; cpu_rw = 1'b0; cpu_a14 = 1'b1; cpu_data = 8'h0F; rom_data = 8'hFF;
    #1 chk("R5 locked oe during write", rom_oe_n, 0);
    chk("R5 locked we stays high", rom_we_n, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_flash();
    logic [7:0] v;
    cfg_flashable = 1'b1; cfg_big = 1'b1;
    bus_write(1'b1, 8'h3C, 8'h00);
    read_latch(v);
    chk("R6 flash load ignores rom_data", v, 8'h3C);
    @(negedge clk);
    romsel_n = 1'b0; cpu_rw = 1'b0; cpu_a14 = 1'b0; cpu_data = 8'h55; rom_data = 8'hFF;
    #1 chk("R7 flash we low", rom_we_n, 0);
    chk("R8 flash oe high on write", rom_oe_n, 1);
    @(negedge clk); idle();
    read_latch(v);
    chk("R7 latch unchanged by flash write", v, 8'h3C);
    @(negedge clk);
    romsel_n = 1'b0; cpu_rw = 1'b1; cpu_a14 = 1'b0;
    #1 chk("R8 flash oe low on read", rom_oe_n, 0);
    chk("R8 flash we high on read", rom_we_n, 1);
    @(negedge clk); idle();
  endtask

  task automatic t_small();
    cfg_big = 1'b0;
    cpu_a14 = 1'b0;
    #1 chk("R3 256K bank masks bit4", rom_bank, 5'h0c);
    cpu_a14 = 1'b1;
    #1 chk("R3 256K fixed window", rom_bank, 5'h0f);
    cpu_a14 = 1'b0;
    cfg_big = 1'b1;
    #1 chk("R3 512K uses bit4", rom_bank, 5'h1c);
  endtask

  task automatic t_nosel();
    logic [7:0] v;
    for (int m = 0; m < 2; m++) begin
      cfg_flashable = m[0];
      @(negedge clk);
      romsel_n = 1'b1; cpu_rw = 1'b0; cpu_a14 = 1'b1; cpu_data = 8'hFF; rom_data = 8'hFF;
      #1 chk("R9 no select oe", rom_oe_n, 1);
      chk("R9 no select we", rom_we_n, 1);
      @(negedge clk); idle();
      read_latch(v);
      chk("R9 write below range ignored", v, 8'h3C);
    end
  endtask

  task automatic t_async_reset();
    logic [7:0] v;
    @(negedge clk);
    #3 rst_n = 1'b0;
    #1 read_latch(v);
    chk("R10 async clear", v, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    // write presented in the first cycle after release must be dropped
    cfg_flashable = 1'b1;
    romsel_n = 1'b0; cpu_rw = 1'b0; cpu_a14 = 1'b1; cpu_data = 8'h77;
    @(negedge clk); idle();
    read_latch(v);
    chk("R10 write during sync release dropped", v, 8'h00);
    repeat (2) @(negedge clk);
    bus_write(1'b1, 8'h81, 8'h00);
    read_latch(v);
    chk("R10 write accepted after release", v, 8'h81);
  endtask

  initial begin
    rst_n = 1'b0; cfg_flashable = 1'b0; cfg_big = 1'b1;
    cpu_data = 8'h00; rom_data = 8'h00;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_locked();
    t_flash();
    t_small();
    t_nosel();
    t_async_reset();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule